// File: doc/BRIEF.md
# Cache Watch Register Window

This block gives software a small register window through which one entry of a table held in memory can be read and rewritten. The aim is to keep an on-chip cache of that table coherent with memory. Software first writes a selector register that names the entry by a block number and an index. It then reads data word 0. That read pulls every word of the entry from memory into a bank of data registers. The remaining words are then read from the bank with no further memory traffic.

To update the entry, software writes the data words from the highest down to word 1, which only latches them. It writes word 0 last, and that write sends all words back to memory. The parameter `NWORDS` sets the number of 64-bit words per entry. One variant uses 4 words and another uses 8.

Memory traffic runs one word at a time over a valid/ready request port with a one-response-per-request return path. A failed fetch leaves zeros in the bank and raises a sticky error flag. Two scrub registers are present only so that software writes to them complete.

Top module: `cwin_top`

## Requirements
- R1: A write to the selector (register address 0) stores the written value, except that bit 62 (the conflict flag) is forced to 0. The index sits in bits [IDX_W-1:0] and the block number in bits [32+BLK_W-1:32].
- R2: A read of the selector returns the stored value with bit 63 (the full-update flag) and bit 62 (the conflict flag) both 0.
- R3: A read of data word 0 (register address 8) stalls the bus until all NWORDS words of the selected entry have been fetched. The words are requested in ascending word order and use the selector's block and index. The read then returns word 0.
- R4: A read of data word w, for w in 1 to NWORDS-1 (address 8+w), returns the latched value and issues no memory request.
- R5: A write to data word w, for w in 1 to NWORDS-1, latches the value and issues no memory request.
- R6: A write to data word 0 completes at once. It then writes all NWORDS latched words to the selected entry, in ascending word order.
- R7: An error response during a fetch leaves every data word at 0. It also sets bit 0 of the status register (address 3), and that bit stays set until software writes 1 to it.
- R8: While a fetch or commit is in progress, every other bus access is held with ready low. The access then takes effect after the transfer ends, so a selector write queued behind a commit does not change the commit's target.
- R9: Writes to the scrub trigger (address 1) and scrub mask (address 2) complete and change nothing. Reads of them return 0.
- R10: At most one memory request is outstanding: after a request is accepted, no new one is raised until its response returns.
- R11: A raised memory request holds its valid and word number until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_ready | output | 1 | Access completes on a clock edge where sel and ready are high |
| bus_rdata | output | 64 | Read data, valid while ready is high |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = commit word, 0 = fetch word |
| mem_req_blk | output | BLK_W | Entry block number |
| mem_req_idx | output | IDX_W | Entry index |
| mem_req_word | output | CNT_W | Word number within entry |
| mem_req_wdata | output | DW | Commit data |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_err | input | 1 | Request failed or entry missing |
| mem_rsp_data | input | DW | Fetched word |

## Verification
The case that matters most is a commit whose last memory response lands in the same cycle that a queued selector write becomes eligible to complete. The bench provokes it by writing data word 0 and then immediately writing a new selector while the memory port throttles acceptance. It then checks that all commit words reached the old entry and that the stall was nonzero. Finally it reads the selector back, and a later fetch must use the new entry.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
   localparam int REG_AW = 4;
   localparam logic [REG_AW-1:0] A_SELECTOR   = 4'd0;
   localparam logic [REG_AW-1:0] A_SCRUB_TRIG = 4'd1;
   localparam logic [REG_AW-1:0] A_SCRUB_MASK = 4'd2;
   localparam logic [REG_AW-1:0] A_STATUS     = 4'd3;
   localparam int SEL_FULL_BIT     = 63;
   localparam int SEL_CONFLICT_BIT = 62;
   localparam int SEL_BLK_LSB      = 32;

   typedef struct packed {
      logic selector;
      logic scrub;
      logic status;
      logic data;
      logic data0;
   } reg_hit_t;

   typedef enum logic [2:0] {
      SQ_IDLE, SQ_FREQ, SQ_FWAIT, SQ_FDONE, SQ_CREQ, SQ_CWAIT
   } seq_state_e;
endpackage

// File: rtl/cwin_decode.sv
module cwin_decode
   import cwin_pkg::*;
#(
   parameter int NWORDS = 4,
   localparam int CNT_W = $clog2(NWORDS)
) (
   input  logic [REG_AW-1:0] addr,
   output reg_hit_t          hit,
   output logic [CNT_W-1:0]  widx
);
   logic [2:0] low;

   assign low  = addr[2:0];
   assign widx = low[CNT_W-1:0];

   always_comb begin
      hit          = '0;
      hit.selector = (addr == A_SELECTOR);
      hit.scrub    = (addr == A_SCRUB_TRIG) || (addr == A_SCRUB_MASK);
      hit.status   = (addr == A_STATUS);
      hit.data     = addr[3] && ({29'd0, low} < NWORDS);
      hit.data0    = hit.data && (low == 3'd0);
   end
endmodule

// File: rtl/cwin_regs.sv
module cwin_regs
   import cwin_pkg::*;
#(
   parameter int NWORDS = 4,
   parameter int DW     = 64,
   parameter int BLK_W  = 4,
   parameter int IDX_W  = 16,
   localparam int CNT_W = $clog2(NWORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  reg_hit_t                     hit,
   input  logic [CNT_W-1:0]             widx,
   input  logic [DW-1:0]                wdata,
   input  logic                         ld_en,
   input  logic [CNT_W-1:0]             ld_widx,
   input  logic [DW-1:0]                ld_data,
   input  logic                         clr_all,
   input  logic                         err_set,
   output logic [BLK_W-1:0]             sel_blk,
   output logic [IDX_W-1:0]             sel_idx,
   output logic [NWORDS-1:0][DW-1:0]    data_q,
   output logic [DW-1:0]                rdata
);
   localparam logic [DW-1:0] FLAG_MASK =
      (DW'(1) << SEL_FULL_BIT) | (DW'(1) << SEL_CONFLICT_BIT);

   logic [DW-1:0] selector_q;
   logic          err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         selector_q <= '0;
      end else if (wr_en && hit.selector) begin
         selector_q <= wdata & ~(DW'(1) << SEL_CONFLICT_BIT);
      end
   end

   assign sel_blk = selector_q[SEL_BLK_LSB +: BLK_W];
   assign sel_idx = selector_q[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if (err_set) begin
         err_q <= 1'b1;
      end else if (wr_en && hit.status && wdata[0]) begin
         err_q <= 1'b0;
      end
   end

   for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n || clr_all) begin
            data_q[gi] <= '0;
         end else if (ld_en && (ld_widx == CNT_W'(gi))) begin
            data_q[gi] <= ld_data;
         end else if (wr_en && hit.data && (widx == CNT_W'(gi))) begin
            data_q[gi] <= wdata;
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit.selector)    rdata = selector_q & ~FLAG_MASK;
      else if (hit.status) rdata = {{(DW-1){1'b0}}, err_q};
      else if (hit.data)   rdata = data_q[widx];
   end

   a_r1_conflict_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en && hit.selector) |-> !selector_q[SEL_CONFLICT_BIT]);
   a_r7_zero_after_error: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_all) |-> (data_q == '0));
   a_r7_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_set) |-> err_q);
endmodule

// File: rtl/cwin_seq.sv
module cwin_seq
   import cwin_pkg::*;
#(
   parameter int NWORDS = 4,
   parameter int DW     = 64,
   parameter int BLK_W  = 4,
   parameter int IDX_W  = 16,
   localparam int CNT_W = $clog2(NWORDS)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         bus_sel,
   input  logic                         bus_wr,
   input  logic                         hit_data0,
   input  logic [BLK_W-1:0]             sel_blk,
   input  logic [IDX_W-1:0]             sel_idx,
   input  logic [NWORDS-1:0][DW-1:0]    data_q,
   output logic                         bus_ready,
   output logic                         mem_req_valid,
   input  logic                         mem_req_ready,
   output logic                         mem_req_write,
   output logic [BLK_W-1:0]             mem_req_blk,
   output logic [IDX_W-1:0]             mem_req_idx,
   output logic [CNT_W-1:0]             mem_req_word,
   output logic [DW-1:0]                mem_req_wdata,
   input  logic                         mem_rsp_valid,
   input  logic                         mem_rsp_err,
   input  logic [DW-1:0]                mem_rsp_data,
   output logic                         ld_en,
   output logic [CNT_W-1:0]             ld_widx,
   output logic [DW-1:0]                ld_data,
   output logic                         clr_all,
   output logic                         err_set
);
   seq_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             err_seen_q;
   logic             rd0, wr0, last;

   assign rd0  = bus_sel && !bus_wr && hit_data0;
   assign wr0  = bus_sel &&  bus_wr && hit_data0;
   assign last = (cnt_q == CNT_W'(NWORDS-1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= SQ_IDLE;
         cnt_q      <= '0;
         err_seen_q <= 1'b0;
      end else begin
         unique case (state_q)
            SQ_IDLE: begin
               cnt_q <= '0;
               if (rd0) begin
                  state_q    <= SQ_FREQ;
                  err_seen_q <= 1'b0;
               end else if (wr0) begin
                  state_q <= SQ_CREQ;
               end
            end
            SQ_FREQ:  if (mem_req_ready) state_q <= SQ_FWAIT;
            SQ_FWAIT: if (mem_rsp_valid) begin
               if (mem_rsp_err) err_seen_q <= 1'b1;
               if (last) state_q <= SQ_FDONE;
               else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= SQ_FREQ;
               end
            end
            SQ_FDONE: state_q <= SQ_IDLE;
            SQ_CREQ:  if (mem_req_ready) state_q <= SQ_CWAIT;
            SQ_CWAIT: if (mem_rsp_valid) begin
               if (last) state_q <= SQ_IDLE;
               else begin
                  cnt_q   <= cnt_q + 1'b1;
                  state_q <= SQ_CREQ;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (state_q)
         SQ_IDLE:  bus_ready = !rd0;
         SQ_FDONE: bus_ready = rd0;
         default:  bus_ready = 1'b0;
      endcase
   end

   assign mem_req_valid = (state_q == SQ_FREQ) || (state_q == SQ_CREQ);
   assign mem_req_write = (state_q == SQ_CREQ);
   assign mem_req_blk   = sel_blk;
   assign mem_req_idx   = sel_idx;
   assign mem_req_word  = cnt_q;
   assign mem_req_wdata = data_q[cnt_q];

   assign ld_en   = (state_q == SQ_FWAIT) && mem_rsp_valid;
   assign ld_widx = cnt_q;
   assign ld_data = (err_seen_q || mem_rsp_err) ? '0 : mem_rsp_data;
   assign clr_all = ld_en && mem_rsp_err && !err_seen_q;
   assign err_set = mem_rsp_valid && mem_rsp_err &&
                    ((state_q == SQ_FWAIT) || (state_q == SQ_CWAIT));

   a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);
   a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_word)));
   a_r3_fetch_stalls_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_write) |-> !bus_ready);
   a_r8_commit_stalls_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_write) |-> !bus_ready);
endmodule

// File: rtl/cwin_top.sv
module cwin_top
   import cwin_pkg::*;
#(
   parameter int NWORDS = 4,
   parameter int DW     = 64,
   parameter int BLK_W  = 4,
   parameter int IDX_W  = 16,
   localparam int CNT_W = $clog2(NWORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [REG_AW-1:0] bus_addr,
   input  logic [DW-1:0]     bus_wdata,
   output logic              bus_ready,
   output logic [DW-1:0]     bus_rdata,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [BLK_W-1:0]  mem_req_blk,
   output logic [IDX_W-1:0]  mem_req_idx,
   output logic [CNT_W-1:0]  mem_req_word,
   output logic [DW-1:0]     mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic              mem_rsp_err,
   input  logic [DW-1:0]     mem_rsp_data
);
   if (!(NWORDS == 2 || NWORDS == 4 || NWORDS == 8)) begin : g_bad_words
      $error("cwin_top: NWORDS must be 2, 4 or 8");
   end
   if (DW != 64) begin : g_bad_dw
      $error("cwin_top: DW must be 64, flag bits sit at 62 and 63");
   end
   if (IDX_W > SEL_BLK_LSB || BLK_W < 1 || BLK_W > SEL_CONFLICT_BIT - SEL_BLK_LSB) begin : g_bad_fields
      $error("cwin_top: selector fields overlap");
   end

   reg_hit_t                    hit;
   logic [CNT_W-1:0]            widx;
   logic [BLK_W-1:0]            sel_blk;
   logic [IDX_W-1:0]            sel_idx;
   logic [NWORDS-1:0][DW-1:0]   data_q;
   logic                        ld_en, clr_all, err_set;
   logic [CNT_W-1:0]            ld_widx;
   logic [DW-1:0]               ld_data;
   logic                        wr_en;

   assign wr_en = bus_sel && bus_wr && bus_ready;

   cwin_decode #(.NWORDS(NWORDS)) u_dec (
      .addr (bus_addr),
      .hit  (hit),
      .widx (widx)
   );

   cwin_regs #(.NWORDS(NWORDS), .DW(DW), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .hit     (hit),
      .widx    (widx),
      .wdata   (bus_wdata),
      .ld_en   (ld_en),
      .ld_widx (ld_widx),
      .ld_data (ld_data),
      .clr_all (clr_all),
      .err_set (err_set),
      .sel_blk (sel_blk),
      .sel_idx (sel_idx),
      .data_q  (data_q),
      .rdata   (bus_rdata)
   );

   cwin_seq #(.NWORDS(NWORDS), .DW(DW), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_sel       (bus_sel),
      .bus_wr        (bus_wr),
      .hit_data0     (hit.data0),
      .sel_blk       (sel_blk),
      .sel_idx       (sel_idx),
      .data_q        (data_q),
      .bus_ready     (bus_ready),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_blk   (mem_req_blk),
      .mem_req_idx   (mem_req_idx),
      .mem_req_word  (mem_req_word),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_err   (mem_rsp_err),
      .mem_rsp_data  (mem_rsp_data),
      .ld_en         (ld_en),
      .ld_widx       (ld_widx),
      .ld_data       (ld_data),
      .clr_all       (clr_all),
      .err_set       (err_set)
   );

   a_r9_scrub_no_traffic: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && hit.scrub && bus_ready) |=> !mem_req_valid);
endmodule

// File: tb/cwin_top_tb_top.sv
`timescale 1ns/1ps
module cwin_top_tb_top;
   localparam int NW     = 8;
   localparam int CW     = 3;
   localparam int ERRIDX = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [63:0] bus_wdata = '0;
   logic        bus_ready;
   logic [63:0] bus_rdata;
   logic        mem_req_valid, mem_req_write;
   logic        mem_rdy = 1'b1;
   logic [3:0]  mem_req_blk;
   logic [15:0] mem_req_idx;
   logic [CW-1:0] mem_req_word;
   logic [63:0] mem_req_wdata;
   logic        rsp_valid, rsp_err;
   logic [63:0] rsp_data;

   int total = 0, bad = 0;
   bit stall_mode = 0;

   always #2 clk = ~clk;

   cwin_top #(.NWORDS(NW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ready(bus_ready), .bus_rdata(bus_rdata),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_rdy), .mem_req_write(mem_req_write),
      .mem_req_blk(mem_req_blk), .mem_req_idx(mem_req_idx), .mem_req_word(mem_req_word),
      .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(rsp_valid), .mem_rsp_err(rsp_err), .mem_rsp_data(rsp_data)
   );

   // memory model, request log and protocol monitors
   logic [63:0] mem [0:1][0:15][0:NW-1];
   logic        log_wr  [0:63];
   logic [3:0]  log_blk [0:63];
   logic [15:0] log_idx [0:63];
   logic [CW-1:0] log_word [0:63];
   int log_n = 0, overlap = 0, unheld = 0;
   logic prev_wait = 1'b0;
   logic [CW-1:0] prev_word = '0;

   function automatic logic [63:0] init_val(int b, int i, int w);
      return {16'hC0DE, 8'(b), 8'(i), 8'(w), 24'h5A5A5A};
   endfunction

   always @(negedge clk) mem_rdy <= stall_mode ? ~mem_rdy : 1'b1;

   always @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_data <= '0;
         for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++)
               for (int w = 0; w < NW; w++) mem[b][i][w] <= init_val(b, i, w);
      end else begin
         if (mem_req_valid && rsp_valid) overlap <= overlap + 1;
         if (prev_wait && (!mem_req_valid || mem_req_word != prev_word)) unheld <= unheld + 1;
         prev_wait <= mem_req_valid && !mem_rdy;
         prev_word <= mem_req_word;
         rsp_valid <= 1'b0;
         if (mem_req_valid && mem_rdy) begin
            rsp_valid <= 1'b1;
            rsp_err   <= (mem_req_idx == 16'(ERRIDX));
            rsp_data  <= mem[mem_req_blk[0]][mem_req_idx[3:0]][mem_req_word];
            if (mem_req_write && mem_req_idx != 16'(ERRIDX))
               mem[mem_req_blk[0]][mem_req_idx[3:0]][mem_req_word] <= mem_req_wdata;
            if (log_n < 64) begin
               log_wr[log_n]   <= mem_req_write;
               log_blk[log_n]  <= mem_req_blk;
               log_idx[log_n]  <= mem_req_idx;
               log_word[log_n] <= mem_req_word;
            end
            log_n <= log_n + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [3:0] a, input logic [63:0] d,
                       output logic [63:0] q, output int stalls);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d; stalls = 0;
      #1;
      while (!bus_ready) begin
         @(negedge clk); #1; stalls++;
      end
      q = bus_rdata;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   function automatic logic [63:0] sel_val(int blk, int idx, bit full, bit conf);
      return {full, conf, 26'h2AB_CDEF >> 0, 4'(blk), 16'h1234, 16'(idx)};
   endfunction

   task automatic check_log(input int base, input bit wr, input int blk, input int idx, input string req);
      for (int k = 0; k < NW; k++) begin
         chk(log_wr[base+k] == wr && log_blk[base+k] == 4'(blk) &&
             log_idx[base+k] == 16'(idx) && log_word[base+k] == CW'(k), req,
             {log_wr[base+k], 27'd0, log_blk[base+k], log_idx[base+k], 13'd0, log_word[base+k]},
             {wr, 27'd0, 4'(blk), 16'(idx), 13'd0, CW'(k)});
      end
   endtask

   task automatic t_reset;
      logic [63:0] q; int s;
      chk(bus_ready === 1'b1, "R8 reset idle ready", {63'd0, bus_ready}, 64'd1);
      chk(mem_req_valid === 1'b0, "R10 reset no request", {63'd0, mem_req_valid}, 64'd0);
      xfer(0, 4'd3, '0, q, s);
      chk(q == 64'd0, "R7 reset status", q, 64'd0);
      xfer(0, 4'd0, '0, q, s);
      chk(q == 64'd0, "R2 reset selector", q, 64'd0);
   endtask

   task automatic t_selector;
      logic [63:0] q, v; int s;
      v = sel_val(1, 5, 1, 1);
      xfer(1, 4'd0, v, q, s);
      xfer(0, 4'd0, '0, q, s);
      chk(q == (v & ~(64'h3 << 62)), "R1 R2 selector readback", q, v & ~(64'h3 << 62));
   endtask

   task automatic t_fetch(input int blk, input int idx);
      logic [63:0] q; int s, base;
      base = log_n;
      xfer(0, 4'd8, '0, q, s);
      chk(q == mem[blk][idx][0] && s > 0, "R3 fetch word0 after stall", q, mem[blk][idx][0]);
      chk(log_n == base + NW, "R3 fetch request count", 64'(log_n - base), 64'(NW));
      check_log(base, 0, blk, idx, "R3 fetch order");
      for (int w = 1; w < NW; w++) begin
         xfer(0, 4'(8 + w), '0, q, s);
         chk(q == mem[blk][idx][w] && s == 0, "R4 latched word read", q, mem[blk][idx][w]);
      end
      chk(log_n == base + NW, "R4 no extra traffic", 64'(log_n - base), 64'(NW));
   endtask

   task automatic t_commit_race;
      logic [63:0] q, nv; int s, base;
      logic [63:0] exp [0:NW-1];
      base = log_n;
      for (int w = NW - 1; w >= 1; w--) begin
         exp[w] = 64'hABCD_0000_0000_0000 | 64'(w * 17);
         xfer(1, 4'(8 + w), exp[w], q, s);
      end
      chk(log_n == base, "R5 high word writes silent", 64'(log_n - base), 64'd0);
      exp[0] = 64'hFEED_FACE_0000_0001;
      xfer(1, 4'd8, exp[0], q, s);
      nv = sel_val(1, 6, 0, 1);
      xfer(1, 4'd0, nv, q, s);
      chk(s > 0, "R8 selector write held during commit", 64'(s), 64'd1);
      chk(log_n == base + NW, "R6 commit request count", 64'(log_n - base), 64'(NW));
      check_log(base, 1, 1, 5, "R6 R8 commit to old entry");
      for (int w = 0; w < NW; w++)
         chk(mem[1][5][w] == exp[w], "R6 committed data", mem[1][5][w], exp[w]);
      xfer(0, 4'd0, '0, q, s);
      chk(q == (nv & ~(64'h3 << 62)), "R8 queued selector applied", q, nv & ~(64'h3 << 62));
   endtask

   task automatic t_error;
      logic [63:0] q; int s;
      xfer(1, 4'd0, sel_val(0, ERRIDX, 0, 0), q, s);
      xfer(0, 4'd8, '0, q, s);
      chk(q == 64'd0, "R7 error word0 zero", q, 64'd0);
      for (int w = 1; w < NW; w++) begin
         xfer(0, 4'(8 + w), '0, q, s);
         chk(q == 64'd0, "R7 error words zero", q, 64'd0);
      end
      xfer(0, 4'd3, '0, q, s);
      chk(q == 64'd1, "R7 sticky set", q, 64'd1);
      xfer(1, 4'd3, 64'd0, q, s);
      xfer(0, 4'd3, '0, q, s);
      chk(q == 64'd1, "R7 write 0 keeps flag", q, 64'd1);
      xfer(1, 4'd3, 64'd1, q, s);
      xfer(0, 4'd3, '0, q, s);
      chk(q == 64'd0, "R7 write 1 clears flag", q, 64'd0);
   endtask

   task automatic t_scrub;
      logic [63:0] q, spec_before, d1_before; int s, base;
      xfer(0, 4'd0, '0, spec_before, s);
      xfer(0, 4'd9, '0, d1_before, s);
      base = log_n;
      xfer(1, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, q, s);
      chk(s == 0, "R9 scrub trigger accepted", 64'(s), 64'd0);
      xfer(1, 4'd2, 64'h0123_4567_89AB_CDEF, q, s);
      xfer(0, 4'd1, '0, q, s);
      chk(q == 64'd0, "R9 scrub trigger reads 0", q, 64'd0);
      xfer(0, 4'd2, '0, q, s);
      chk(q == 64'd0, "R9 scrub mask reads 0", q, 64'd0);
      xfer(0, 4'd0, '0, q, s);
      chk(q == spec_before, "R9 selector untouched", q, spec_before);
      xfer(0, 4'd9, '0, q, s);
      chk(q == d1_before, "R9 data untouched", q, d1_before);
      chk(log_n == base, "R9 no traffic", 64'(log_n - base), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [63:0] q; int s;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_selector;
      stall_mode = 1;
      t_fetch(1, 5);
      t_commit_race;
      stall_mode = 0;
      t_fetch(1, 6);
      xfer(1, 4'd0, sel_val(1, 5, 0, 0), q, s);
      t_fetch(1, 5);
      t_error;
      t_scrub;
      chk(overlap == 0, "R10 single outstanding", 64'(overlap), 64'd0);
      chk(unheld == 0, "R11 request held", 64'(unheld), 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule